// File: doc/BRIEF.md
# Interval Down-Counter Timer

A 32-bit interval timer driven by a one-cycle command strobe that carries an 8-bit operation code and a 32-bit operand. The code picks one of six operations: halt the count, start a single countdown, start a repeating countdown, read the count, read then halt, or read then start a fresh single countdown. Codes outside the six are ignored. Each read returns its value on a response bus one cycle after the strobe.

A prescaler turns the system clock into count ticks. Its period is `TICK_CYCLES` clocks at the fine resolution (38.4 us per count when `TICK_CYCLES` matches the clock) and twice that at the coarse resolution (76.8 us). The prescaler starts again from zero on every command that loads the counter.

When the count reaches zero and the interrupt enable is set, the block raises a one-cycle interrupt pulse. A separate write port sets or clears the enable. Setting it also halts the counter until the next start command.

Top module: `ivt_top`

## Requirements
- R1: While running, the count drops by one every `TICK_CYCLES` clocks when `res_slow`=0, and every 2*`TICK_CYCLES` clocks when `res_slow`=1. Tick phase starts again at each load command (codes 0x39, 0x3D, 0x79).
- R2: Code 0x39 loads `cmd_data` and starts a single countdown with no reload. A zero operand, or one with bit 31 set, loads `DEFAULT_LOAD` (26042) instead.
- R3: In a single countdown the counter keeps counting past zero into two's-complement negative values. The interrupt fires only on the tick that takes the count from 1 to 0.
- R4: Code 0x3D loads `cmd_data`, starts counting and keeps the operand as the reload value. On each tick that would reach zero the count restarts from the reload value and an interrupt is raised, so the period is the operand times the tick period.
- R5: Code 0x40 sets `rsp_valid` for one cycle in the cycle after the strobe. `rsp_data` holds the count as it was before the strobe edge, and the counter keeps running undisturbed.
- R6: Code 0x60 returns the count as in R5 and halts the counter. The count then holds that value.
- R7: Code 0x79 returns the old count as in R5, loads `cmd_data` without substitution, and starts a single countdown that does not reload, even if a repeating countdown was in progress.
- R8: Code 0x20 halts the counter, clears the reload value and gives no response.
- R9: `irq` is a one-cycle pulse, asserted in the cycle after the zero-reaching tick edge, and only while the interrupt enable is set.
- R10: A pulse on `ien_wr` loads `ien_val` into the interrupt enable. Writing 1 also halts the counter and leaves the count unchanged.
- R11: Reset clears the count, the reload value and the interrupt enable, and leaves the counter halted.
- R12: Any other code gives no response and changes neither the count nor the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_slow | input | 1 | 0: tick every TICK_CYCLES clocks; 1: every 2*TICK_CYCLES |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 8 | Operation code |
| cmd_data | input | CNT_W | Load operand |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_val | input | 1 | Interrupt enable value to write |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | CNT_W | Count returned by a read code |
| irq | output | 1 | Zero-reached interrupt pulse |

## Verification
The assertions assume that `cmd_valid` and `ien_wr` are single-cycle strobes. They also assume that any change of `res_slow` takes effect only after the next load, since the checker treats tick phase as undefined across a resolution change. The bench drives every strobe for exactly one clock, changes `res_slow` only just before a load command, and never issues a command and an enable write in the same cycle. The checker keeps its own copy of the interrupt enable, built from the write port alone, and uses it to judge every `irq` pulse.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam logic [7:0] OP_HALT       = 8'h20;
    localparam logic [7:0] OP_START_ONCE = 8'h39;
    localparam logic [7:0] OP_START_AUTO = 8'h3D;
    localparam logic [7:0] OP_PEEK       = 8'h40;
    localparam logic [7:0] OP_PEEK_HALT  = 8'h60;
    localparam logic [7:0] OP_PEEK_START = 8'h79;

    typedef struct packed {
        logic rd;       // return current count
        logic ld;       // load operand and run
        logic stop;     // halt counting
        logic auto_rl;  // keep operand as reload value
        logic clr_rl;   // forget reload value
    } ivt_op_t;
endpackage

// File: rtl/ivt_decode.sv
module ivt_decode #(
    parameter int CNT_W = 32,
    parameter int DEFAULT_LOAD = 26042
) (
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_code,
    input  logic [CNT_W-1:0]     cmd_data,
    output ivt_pkg::ivt_op_t     op,
    output logic [CNT_W-1:0]     ld_val
);
    import ivt_pkg::*;

    localparam logic [CNT_W-1:0] SUBST = CNT_W'(DEFAULT_LOAD);

    logic not_positive;

    always_comb begin
        not_positive = cmd_data[CNT_W-1] || (cmd_data == '0);
        op = '0;
        ld_val = cmd_data;
        if (cmd_valid) begin
            case (cmd_code)
                OP_HALT: begin
                    op.stop   = 1'b1;
                    op.clr_rl = 1'b1;
                end
                OP_START_ONCE: begin
                    op.ld     = 1'b1;
                    op.clr_rl = 1'b1;
                    ld_val    = not_positive ? SUBST : cmd_data;
                end
                OP_START_AUTO: begin
                    op.ld      = 1'b1;
                    op.auto_rl = 1'b1;
                end
                OP_PEEK: begin
                    op.rd = 1'b1;
                end
                OP_PEEK_HALT: begin
                    op.rd   = 1'b1;
                    op.stop = 1'b1;
                end
                OP_PEEK_START: begin
                    op.rd     = 1'b1;
                    op.ld     = 1'b1;
                    op.clr_rl = 1'b1;
                end
                default: op = '0;
            endcase
        end
    end
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int TICK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic res_slow,
    output logic tick
);
    localparam int PW = $clog2(2 * TICK_CYCLES + 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(TICK_CYCLES);
    localparam logic [PW-1:0] LIM_SLOW = PW'(2 * TICK_CYCLES);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] last;

    always_comb begin
        last = (res_slow ? LIM_SLOW : LIM_FAST) - PW'(1);
        tick = 1'b0;
        if (!run || restart) begin
            pre_d = '0;
        end else if (pre_q >= last) begin
            pre_d = '0;
            tick  = 1'b1;
        end else begin
            pre_d = pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/ivt_core.sv
module ivt_core #(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ivt_pkg::ivt_op_t     op,
    input  logic [CNT_W-1:0]     ld_val,
    input  logic                 tick,
    input  logic                 ien_wr,
    input  logic                 ien_val,
    output logic                 running,
    output logic                 rsp_valid,
    output logic [CNT_W-1:0]     rsp_data,
    output logic                 irq
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] reload;
        logic             running;
        logic             auto_rl;
        logic             armed;
        logic             irq_en;
        logic             irq;
        logic             rsp_valid;
        logic [CNT_W-1:0] rsp_data;
    } core_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.irq = 1'b0;
        st_d.rsp_valid = 1'b0;

        // tick processing
        if (tick && st_q.running) begin
            st_d.count = st_q.count - ONE;
            if (st_q.count == ONE) begin
                if (st_q.auto_rl) begin
                    st_d.count = st_q.reload;
                    st_d.irq   = st_q.irq_en;
                end else if (st_q.armed) begin
                    st_d.irq   = st_q.irq_en;
                    st_d.armed = 1'b0;
                end
            end
        end

        // command processing overrides tick
        if (op.rd) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_data  = st_q.count;
        end
        if (op.stop) begin
            st_d.running = 1'b0;
            st_d.count   = st_q.count;
        end
        if (op.clr_rl) begin
            st_d.reload  = '0;
            st_d.auto_rl = 1'b0;
        end
        if (op.ld) begin
            st_d.count   = ld_val;
            st_d.running = 1'b1;
            st_d.armed   = 1'b1;
            st_d.auto_rl = op.auto_rl;
            if (op.auto_rl) st_d.reload = ld_val;
        end

        // interrupt enable control
        if (ien_wr) begin
            st_d.irq_en = ien_val;
            if (ien_val) st_d.running = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running   = st_q.running;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;
    assign irq       = st_q.irq;
endmodule

// File: rtl/ivt_top.sv
module ivt_top #(
    parameter int CNT_W        = 32,
    parameter int TICK_CYCLES  = 4,
    parameter int DEFAULT_LOAD = 26042
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_slow,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    input  logic [CNT_W-1:0] cmd_data,
    input  logic             ien_wr,
    input  logic             ien_val,
    output logic             rsp_valid,
    output logic [CNT_W-1:0] rsp_data,
    output logic             irq
);
    ivt_pkg::ivt_op_t op;
    logic [CNT_W-1:0] ld_val;
    logic             tick;
    logic             running;

    ivt_decode #(.CNT_W(CNT_W), .DEFAULT_LOAD(DEFAULT_LOAD)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .op        (op),
        .ld_val    (ld_val)
    );

    ivt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (op.ld),
        .res_slow (res_slow),
        .tick     (tick)
    );

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ld_val    (ld_val),
        .tick      (tick),
        .ien_wr    (ien_wr),
        .ien_val   (ien_val),
        .running   (running),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .irq       (irq)
    );
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_code,
    input logic       ien_wr,
    input logic       ien_val,
    input logic       rsp_valid,
    input logic       irq,
    input logic       running
);
    import ivt_pkg::*;

    logic en_model;
    logic is_known;
    logic is_read;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_model <= 1'b0;
        else if (ien_wr) en_model <= ien_val;
    end

    assign is_read  = (cmd_code == OP_PEEK) || (cmd_code == OP_PEEK_HALT) ||
                      (cmd_code == OP_PEEK_START);
    assign is_known = is_read || (cmd_code == OP_HALT) ||
                      (cmd_code == OP_START_ONCE) || (cmd_code == OP_START_AUTO);

    // R9: an interrupt pulse needs the enable held in the cycle before it
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_model));

    // R5: every read code answers in the next cycle
    p_read_answers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_read) |=> rsp_valid);

    // R12: unknown codes neither answer nor change the run state
    p_unknown_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !is_known && !ien_wr) |=> (!rsp_valid && $stable(running)));

    // R6: read-and-halt leaves the counter halted
    p_peek_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_PEEK_HALT) |=> !running);

    // R8: halt gives no answer and stops the counter
    p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_HALT && !ien_wr) |=> (!running && !rsp_valid));

    // R10: enabling interrupts halts the counter
    p_enable_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && ien_val) |=> !running);
endmodule

bind ivt_top ivt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .ien_wr    (ien_wr),
    .ien_val   (ien_val),
    .rsp_valid (rsp_valid),
    .irq       (irq),
    .running   (running)
);

// File: tb/sim_ivt_top.sv
module sim_ivt_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS = 4;
    localparam int WDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_slow = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = '0;
    logic [31:0] cmd_data = '0;
    logic        ien_wr = 1'b0;
    logic        ien_val = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    int base;
    logic        r_v;
    logic [31:0] r_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_top #(.CNT_W(32), .TICK_CYCLES(TICKS), .DEFAULT_LOAD(26042)) u0 (
        .clk(clk), .rst_n(rst_n), .res_slow(res_slow),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
        .ien_wr(ien_wr), .ien_val(ien_val),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    // {res_slow, operand, wait cycles, expected read}
    localparam logic [72:0] VEC [10] = '{
        {1'b0, 32'd100,        8'd0,  32'd100},
        {1'b0, 32'd100,        8'd3,  32'd100},
        {1'b0, 32'd100,        8'd4,  32'd99},
        {1'b0, 32'd50,         8'd17, 32'd46},
        {1'b1, 32'd50,         8'd7,  32'd50},
        {1'b1, 32'd50,         8'd8,  32'd49},
        {1'b1, 32'd20,         8'd40, 32'd15},
        {1'b0, 32'd0,          8'd8,  32'd26040},
        {1'b0, 32'hFFFF_FFFF,  8'd0,  32'd26042},
        {1'b0, 32'd2,          8'd12, 32'hFFFF_FFFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the strobe edge
    task automatic issue(input logic [7:0] code, input logic [31:0] data);
        cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        r_v = rsp_valid;
        r_d = rsp_data;
    endtask

    task automatic set_en(input logic v);
        ien_wr = 1'b1; ien_val = v;
        @(posedge clk);
        @(negedge clk);
        ien_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        idle(3);
        chk("R11 irq in reset", {31'd0, irq}, 32'd0);
        chk("R11 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        idle(2);
        issue(8'h40, 32'd0);
        chk("R11 count after reset", r_d, 32'd0);
        idle(10);
        issue(8'h40, 32'd0);
        chk("R11 halted after reset", r_d, 32'd0);

        // R1 R2 R3 R5: vector table
        for (int i = 0; i < 10; i++) begin
            res_slow = VEC[i][72];
            issue(8'h39, VEC[i][71:40]);
            idle(int'(VEC[i][39:32]));
            issue(8'h40, 32'd0);
            chk("R5 read valid", {31'd0, r_v}, 32'd1);
            chk("R1/R2 count", r_d, VEC[i][31:0]);
        end
        res_slow = 1'b0;

        // R3 R9: single countdown fires once on reaching zero
        set_en(1'b1);
        issue(8'h39, 32'd3);
        base = irq_seen;
        idle(11);
        chk("R9 no irq before zero", {31'd0, irq}, 32'd0);
        idle(1);
        chk("R9 irq at zero", {31'd0, irq}, 32'd1);
        idle(1);
        chk("R9 irq one cycle", {31'd0, irq}, 32'd0);
        idle(60);
        chk("R3 single fire", 32'(irq_seen - base), 32'd1);
        issue(8'h40, 32'd0);
        chk("R3 negative count", r_d, 32'hFFFF_FFF1);

        // R9: disabled enable gives no interrupt
        set_en(1'b0);
        issue(8'h39, 32'd3);
        base = irq_seen;
        idle(20);
        chk("R9 no irq when disabled", 32'(irq_seen - base), 32'd0);

        // R4: repeating countdown
        set_en(1'b1);
        issue(8'h3D, 32'd2);
        base = irq_seen;
        idle(25);
        chk("R4 reload pulses", 32'(irq_seen - base), 32'd3);
        issue(8'h20, 32'd0);
        chk("R8 halt no response", {31'd0, r_v}, 32'd0);

        // R7: read, load, single countdown
        issue(8'h39, 32'd100);
        idle(8);
        issue(8'h79, 32'd10);
        chk("R7 valid", {31'd0, r_v}, 32'd1);
        chk("R7 old count", r_d, 32'd98);
        base = irq_seen;
        idle(50);
        chk("R7 one pulse", 32'(irq_seen - base), 32'd1);

        // R7: cancels repeating mode
        issue(8'h3D, 32'd2);
        idle(3);
        issue(8'h79, 32'd3);
        chk("R7 old count from auto", r_d, 32'd2);
        base = irq_seen;
        idle(30);
        chk("R7 no reload after 0x79", 32'(irq_seen - base), 32'd1);

        // R6: read and halt
        issue(8'h39, 32'd100);
        idle(4);
        issue(8'h60, 32'd0);
        chk("R6 valid", {31'd0, r_v}, 32'd1);
        chk("R6 count", r_d, 32'd99);
        idle(20);
        issue(8'h40, 32'd0);
        chk("R6 held", r_d, 32'd99);

        // R8: halt
        issue(8'h3D, 32'd50);
        idle(4);
        issue(8'h20, 32'd0);
        chk("R8 no response", {31'd0, r_v}, 32'd0);
        idle(10);
        issue(8'h40, 32'd0);
        chk("R8 held", r_d, 32'd49);

        // R12: unknown code
        issue(8'h55, 32'd7);
        chk("R12 no response", {31'd0, r_v}, 32'd0);
        idle(10);
        issue(8'h40, 32'd0);
        chk("R12 count unchanged", r_d, 32'd49);

        // R10: enable halts counter
        issue(8'h39, 32'd100);
        set_en(1'b1);
        idle(20);
        issue(8'h40, 32'd0);
        chk("R10 halted by enable", r_d, 32'd100);

        // R11: reset mid-run clears enable and count
        issue(8'h39, 32'd1000);
        idle(5);
        rst_n = 1'b0;
        idle(3);
        chk("R11 irq low in reset", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        idle(1);
        issue(8'h40, 32'd0);
        chk("R11 count cleared", r_d, 32'd0);
        issue(8'h39, 32'd1);
        base = irq_seen;
        idle(10);
        chk("R11 enable cleared", 32'(irq_seen - base), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule